// File: doc/BRIEF.md
# Priority-Aware LRU Replacement for One Cache Set

This block holds the replacement state of a single set in a set-associative cache. It tracks how recently each way was touched, as an ordered list from most recent to least recent, and keeps a one-bit protection flag beside every line. A line that is refilled from the victim bank comes back with its flag set. A line brought in by an ordinary fill comes back with its flag clear.

When the cache controller needs room in the set, the block names the victim way. It picks the least recently used line that is not protected. Protected lines are given up only when every way in the set is protected, and then the plain LRU way is taken.

The controller reports two kinds of event, each with a way index: hits (accesses) and fills. Fills also carry a qualifier that says whether the data came from the victim bank. Tag comparison and data storage stay outside this block.

Top module: `prio_lru_set`

## Requirements
- R1: After a synchronous reset, the recency order from most recent to least recent is way 0, 1, 2, 3, every protection flag is clear, and the victim is way 3.
- R2: An access moves its way to the most recent position. Ways that were more recent than it each move down one place. Ways that were less recent keep their positions.
- R3: A fill moves its way to the most recent position in the same way as an access.
- R4: A fill with the victim-bank qualifier high sets that way's protection flag. A fill with the qualifier low clears it.
- R5: An access leaves every protection flag unchanged.
- R6: While at least one way is unprotected, the victim is the least recent unprotected way.
- R7: When all ways are protected, the victim is the least recent way.
- R8: If an access and a fill arrive in the same cycle, only the fill takes effect and the access is ignored.
- R9: The victim output is computed combinationally from the stored state. It reflects an event in the cycle after that event's clock edge.
- R10: In a cycle with no access and no fill, the order and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access (hit) event this cycle |
| acc_way | input | 2 | Way that was accessed |
| fill_valid | input | 1 | Fill event this cycle |
| fill_way | input | 2 | Way being filled |
| fill_from_vb | input | 1 | Fill data comes from the victim bank |
| victim_way | output | 2 | Way to replace next |

## Verification
The assertions assume the way indices are always in range and that `fill_from_vb` is only meaningful while `fill_valid` is high. They also assume that reset is applied before the first event. The stimulus drives way indices from two-bit fields only, so they cannot go out of range, and it asserts reset before any event. It mixes idle cycles, accesses, fills of both kinds and access-fill collisions. A long pseudo-random run of events lets the protection flags pass through every combination, including all set and all clear.

// File: rtl/prio_lru_pkg.sv
package prio_lru_pkg;
  localparam int unsigned DEF_WAYS = 4;

  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_HIT  = 2'd1,
    EV_FILL = 2'd2
  } lru_event_e;
endpackage

// File: rtl/prio_lru_order.sv
module prio_lru_order #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            touch,
  input  logic [IDX_W-1:0]                touch_way,
  output logic [WAYS-1:0][IDX_W-1:0]      order_o
);
  logic [WAYS-1:0][IDX_W-1:0] order_q, order_d;
  logic [IDX_W-1:0]           hit_pos;
  logic [WAYS-1:0]            seen;

  always_comb begin
    hit_pos = '0;
    for (int i = 0; i < WAYS; i++)
      if (order_q[i] == touch_way) hit_pos = IDX_W'(i);
    order_d = order_q;
    if (touch) begin
      order_d[0] = touch_way;
      for (int i = 1; i < WAYS; i++)
        if (IDX_W'(i) <= hit_pos) order_d[i] = order_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) order_q[i] <= IDX_W'(i);
    end else begin
      order_q <= order_d;
    end
  end

  assign order_o = order_q;

  always_comb begin
    seen = '0;
    for (int i = 0; i < WAYS; i++) seen[order_q[i]] = 1'b1;
  end

  // R2 / R3: touched way lands at the most recent position
  a_r2_to_mru: assert property (@(posedge clk) disable iff (rst)
    touch |=> order_q[0] == $past(touch_way));
  // R2: the order is always a permutation of the ways
  a_r2_permutation: assert property (@(posedge clk) disable iff (rst)
    &seen);
  // R10: no touch, no change
  a_r10_order_hold: assert property (@(posedge clk) disable iff (rst)
    !touch |=> $stable(order_q));
endmodule

// File: rtl/prio_lru_flags.sv
module prio_lru_flags #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_way,
  input  logic             set_val,
  output logic [WAYS-1:0]  flags_o
);
  logic [WAYS-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else if (set_en) flags_q[set_way] <= set_val;
  end

  assign flags_o = flags_q;

  // R4: a fill writes the qualifier into the flag of its way
  a_r4_fill_flag: assert property (@(posedge clk) disable iff (rst)
    set_en |=> flags_q[$past(set_way)] == $past(set_val));
  // R5 / R10: flags move only on fills
  a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !set_en |=> $stable(flags_q));
endmodule

// File: rtl/prio_lru_pick.sv
module prio_lru_pick #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WAYS-1:0][IDX_W-1:0] order_i,
  input  logic [WAYS-1:0]            flags_i,
  output logic [IDX_W-1:0]           victim_o
);
  logic found;

  always_comb begin
    victim_o = order_i[WAYS-1];
    found    = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!found && !flags_i[order_i[i]]) begin
        victim_o = order_i[i];
        found    = 1'b1;
      end
    end
  end

  // R6: an unprotected way exists, so the victim is unprotected
  a_r6_pick_unprotected: assert property (@(posedge clk) disable iff (rst)
    !(&flags_i) |-> !flags_i[victim_o]);
  // R7: all protected, fall back to the plain LRU way
  a_r7_all_protected: assert property (@(posedge clk) disable iff (rst)
    (&flags_i) |-> victim_o == order_i[WAYS-1]);
endmodule

// File: rtl/prio_lru_set.sv
module prio_lru_set
  import prio_lru_pkg::*;
#(
  parameter int unsigned WAYS  = DEF_WAYS,
  parameter int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_way,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_way,
  input  logic             fill_from_vb,
  output logic [IDX_W-1:0] victim_way
);
  lru_event_e                 ev;
  logic [IDX_W-1:0]           ev_way;
  logic [WAYS-1:0][IDX_W-1:0] order;
  logic [WAYS-1:0]            flags;

  // R8: a fill wins over a simultaneous access
  always_comb begin
    if (fill_valid)     begin ev = EV_FILL; ev_way = fill_way; end
    else if (acc_valid) begin ev = EV_HIT;  ev_way = acc_way;  end
    else                begin ev = EV_IDLE; ev_way = '0;       end
  end

  prio_lru_order #(.WAYS(WAYS), .IDX_W(IDX_W)) u_order (
    .clk(clk), .rst(rst), .touch(ev != EV_IDLE), .touch_way(ev_way),
    .order_o(order));

  prio_lru_flags #(.WAYS(WAYS), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst(rst), .set_en(ev == EV_FILL), .set_way(ev_way),
    .set_val(fill_from_vb), .flags_o(flags));

  prio_lru_pick #(.WAYS(WAYS), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .order_i(order), .flags_i(flags),
    .victim_o(victim_way));

  // R8: on a collision the filled way, not the accessed one, becomes MRU
  a_r8_fill_wins: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && acc_valid) |=> order[0] == $past(fill_way));
endmodule

// File: tb/prio_lru_set_bench.sv
module prio_lru_set_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0, fill_valid = 1'b0, fill_from_vb = 1'b0;
  logic [1:0] acc_way = '0, fill_way = '0;
  logic [1:0] victim_way;

  int n_tests = 0, n_fail = 0;
  int m_order [4];
  bit m_prot  [4];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  prio_lru_set u_prio_lru_set (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_way(acc_way),
    .fill_valid(fill_valid), .fill_way(fill_way), .fill_from_vb(fill_from_vb),
    .victim_way(victim_way));

  function automatic int exp_victim();
    for (int i = 3; i >= 0; i--) if (!m_prot[m_order[i]]) return m_order[i];
    return m_order[3];
  endfunction

  function automatic void promote(int w);
    int p = 0;
    for (int i = 0; i < 4; i++) if (m_order[i] == w) p = i;
    for (int i = p; i > 0; i--) m_order[i] = m_order[i-1];
    m_order[0] = w;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s victim actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, register at posedge, sample at next negedge (R9)
  task automatic step(bit a, int aw, bit f, int fw, bit vb, string req);
    acc_valid = a; acc_way = 2'(aw);
    fill_valid = f; fill_way = 2'(fw); fill_from_vb = vb;
    @(negedge clk);
    acc_valid = 1'b0; fill_valid = 1'b0; fill_from_vb = 1'b0;
    if (f) begin promote(fw); m_prot[fw] = vb; end
    else if (a) promote(aw);
    check(req, int'(victim_way), exp_victim());
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_order[i] = i; m_prot[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset", int'(victim_way), 3);
    step(1, 3, 0, 0, 0, "R2 access");       // order 3,0,1,2
    check("R2 access", int'(victim_way), 2);
    step(0, 0, 1, 2, 1, "R3 fill");         // 2,3,0,1 P2
    check("R3 fill", int'(victim_way), 1);
    step(0, 0, 1, 1, 1, "R4 set");          // 1,2,3,0 P1 P2
    check("R4 set", int'(victim_way), 0);
    step(1, 2, 0, 0, 0, "R5 access");       // 2,1,3,0
    check("R5 access", int'(victim_way), 0);
    step(0, 0, 1, 0, 1, "R6 pick");         // 0,2,1,3 P0 P1 P2
    check("R6 pick", int'(victim_way), 3);
    step(0, 0, 1, 3, 1, "R7 all");          // 3,0,2,1 all
    check("R7 all", int'(victim_way), 1);
    step(0, 0, 1, 2, 0, "R4 clear");        // 2,3,0,1 P2 clear
    check("R4 clear", int'(victim_way), 2);
    step(1, 1, 1, 0, 1, "R8 collide");      // 0,2,3,1: fill 0 wins
    check("R8 collide", int'(victim_way), 2);
    step(0, 0, 0, 0, 0, "R10 idle");
    check("R10 idle", int'(victim_way), 2);
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], int'(lfsr[2:1]), lfsr[3] & lfsr[9], int'(lfsr[5:4]),
           lfsr[6] | lfsr[7], "R6 R7 sweep");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule